// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sits between an I2C master's byte engine and the bus pins. From a fast input clock it produces the SCL drive level and the SDA level for bus conditions. It also produces three strobes: one says when the byte engine may change SDA, one says when it should sample SDA, and one says that a requested sequence has finished. The byte engine asks for one sequence at a time with a command pulse: a single bit clock, a start condition, a stop condition or a repeated start. All durations are counted in prescaled ticks. A tick lasts DIV+1 input cycles.

Two complete timing sets are presented, a fast set and a high-speed set, and `hs_mode` picks one of them. The data-hold count and the glitch-filter length are shared by both sets. The selected values are captured when a command is accepted and stay fixed until that sequence ends. During the high phase of a bit, the generator waits while the sampled SCL line is still low, so a target can stretch the clock.

The controller is a single state machine:

| State | What it does |
|---|---|
| IDLE | Holds SCL at the level the last sequence left. |
| STA_SU | Start setup: SCL high, SDA high. |
| STA_HD | Start hold: SCL high, SDA low. |
| STO_DAT | Stop data setup: SCL low, SDA low. |
| STO_SU | Stop setup: SCL high, SDA low. |
| RS_REL | Restart release: SCL low, SDA high. |
| BIT_LO | Low phase of a bit. |
| BIT_RISE | Fixed overhead after SCL is released. |
| BIT_HI | High phase of a bit, held while SCL is low. |
| BIT_FALL | Fixed overhead after the high phase. |

Transitions:
- IDLE goes to BIT_LO, STA_SU, STO_DAT or RS_REL, according to the opcode.
- RS_REL goes to STA_SU, and STA_SU goes to STA_HD.
- STO_DAT goes to STO_SU.
- BIT_LO goes to BIT_RISE, then to BIT_HI, then to BIT_FALL.
- STA_HD, STO_SU and BIT_FALL each return to IDLE when their phase ends.

Top module: `scl_timing_gen`

## Requirements
- R1: A bit sequence runs in this order, with T = DIV+1 input cycles:
  1. SCL is pulled low for (L+1)·T cycles.
  2. SCL is released and stays released for 4+FLT cycles.
  3. The high phase lasts (H+1)·T cycles.
  4. A further 4+FLT cycles follow.

  SCL is then low again. With no stretching, a bit lasts (DIV+1)·(L+H+2)+8+2·FLT cycles.
- R2: Each 64-bit timing set is packed as follows:

  | Bits | Field |
  |---|---|
  | 63:56 | DIV |
  | 55:48 | L |
  | 47:40 | H |
  | 39:32 | start setup |
  | 31:24 | start hold |
  | 23:16 | stop setup |
  | 15:8 | data setup |
  | 7:0 | restart release |

  Data hold is `dat_hold[7:0]` and FLT is `flt_len[2:0]`.
- R3: When `hs_mode` is 1 at acceptance, `hs_timing` is used; otherwise `fs_timing` is used. Data hold and FLT are shared by both sets.
- R4: A start (opcode 1) runs as follows:
  1. SCL released and SDA high for (start setup+1)·T cycles.
  2. SDA low for (start hold+1)·T cycles, with SCL still released.
  3. SCL is left low in IDLE.

  While the sequence runs, `sda_own` is 1.
- R5: A stop (opcode 2) runs as follows:
  1. SCL low and SDA low for (data setup+1)·T cycles.
  2. SCL released and SDA low for (stop setup+1)·T cycles.
  3. SCL is left released in IDLE.
- R6: A repeated start (opcode 3) holds SCL low and SDA high for (restart release+1)·T cycles. It then runs the full start sequence.
- R7: `drive_stb` pulses for one cycle during the low phase, on the last input cycle of tick number min(data hold, L), counting from 0. `sample_stb` pulses on the last cycle of the high phase.
- R8: In the high phase, the counting freezes on every cycle in which the SCL input, registered once, is low. The phase is lengthened by exactly those cycles.
- R9: Opcode 0 requests a bit. `busy` is 1 from the cycle after acceptance until the sequence ends. `done_stb` pulses on the last busy cycle. A command given while busy is ignored.
- R10: Timing inputs that change while busy do not affect the running sequence.
- R11: After reset the block is in IDLE with SCL released, `busy` is 0 and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | Selects the high-speed timing set |
| fs_timing | input | 64 | Fast timing set |
| hs_timing | input | 64 | High-speed timing set |
| dat_hold | input | 8 | Shared data-hold count |
| flt_len | input | 3 | Glitch-filter length |
| cmd_go | input | 1 | Command request, accepted when idle |
| cmd_op | input | 2 | 0 bit, 1 start, 2 stop, 3 repeated start |
| scl_in | input | 1 | Observed SCL line level |
| scl_release | output | 1 | 1 releases SCL, 0 pulls it low |
| sda_own | output | 1 | Generator controls SDA during a condition |
| sda_level | output | 1 | SDA level while `sda_own` is 1 |
| busy | output | 1 | A sequence is running |
| drive_stb | output | 1 | Byte engine may change SDA |
| sample_stb | output | 1 | Byte engine should sample SDA |
| done_stb | output | 1 | Sequence finished |

## Verification
Some properties are checked on every cycle by assertions:
- the prescaler advances by one each active cycle;
- the counters freeze while a stretch hold is active;
- the three strobes never overlap;
- `done_stb` is always followed by idle;
- a command given while busy leaves the state unchanged;
- the captured timing set stays fixed while busy.

Other behaviour can only be shown by the bench scenarios, which compare against a per-cycle expected waveform built from the requirements:
- the exact phase lengths for each sequence type;
- where the drive and sample strobes fall, including the clamp when data hold exceeds L;
- the selection of the high-speed set;
- the exact extension caused by stretching.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
    localparam int CNT_W     = 8;
    localparam int FLT_W     = 3;
    localparam int N_FIELDS  = 8;
    localparam int SET_W     = CNT_W * N_FIELDS;
    localparam int SYNC_BASE = 3;   // overhead phase lasts SYNC_BASE+1+FLT cycles

    typedef enum logic [1:0] {
        OP_BIT     = 2'd0,
        OP_START   = 2'd1,
        OP_STOP    = 2'd2,
        OP_RESTART = 2'd3
    } tgen_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_STA_SU, ST_STA_HD, ST_STO_DAT, ST_STO_SU,
        ST_RS_REL, ST_BIT_LO, ST_BIT_RISE, ST_BIT_HI, ST_BIT_FALL
    } tgen_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] scl_lo;
        logic [CNT_W-1:0] scl_hi;
        logic [CNT_W-1:0] sta_su;
        logic [CNT_W-1:0] sta_hd;
        logic [CNT_W-1:0] sto_su;
        logic [CNT_W-1:0] dat_su;
        logic [CNT_W-1:0] rs_rel;
        logic [CNT_W-1:0] dat_hd;
        logic [FLT_W-1:0] flt;
    } tgen_timing_t;

    function automatic tgen_timing_t unpack_set(input logic [SET_W-1:0] s,
                                                input logic [CNT_W-1:0] hd,
                                                input logic [FLT_W-1:0] f);
        tgen_timing_t t;
        t.div    = s[7*CNT_W +: CNT_W];
        t.scl_lo = s[6*CNT_W +: CNT_W];
        t.scl_hi = s[5*CNT_W +: CNT_W];
        t.sta_su = s[4*CNT_W +: CNT_W];
        t.sta_hd = s[3*CNT_W +: CNT_W];
        t.sto_su = s[2*CNT_W +: CNT_W];
        t.dat_su = s[1*CNT_W +: CNT_W];
        t.rs_rel = s[0*CNT_W +: CNT_W];
        t.dat_hd = hd;
        t.flt    = f;
        return t;
    endfunction
endpackage

// File: rtl/scl_tgen_select.sv
module scl_tgen_select
    import scl_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hs_mode,
    input  logic [SET_W-1:0] fs_set,
    input  logic [SET_W-1:0] hs_set,
    input  logic [CNT_W-1:0] dat_hold,
    input  logic [FLT_W-1:0] flt_len,
    output tgen_timing_t     cfg
);
    // Capture the selected set once per command; it stays put while busy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (load) begin
            cfg <= unpack_set(hs_mode ? hs_set : fs_set, dat_hold, flt_len);
        end
    end
endmodule

// File: rtl/scl_tgen_phase_cnt.sv
module scl_tgen_phase_cnt
    import scl_tgen_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          hold,
    input  logic          raw_mode,
    input  logic [CW-1:0] div,
    input  logic [CW-1:0] lim,
    output logic          tick,
    output logic          last,
    output logic [CW-1:0] tcnt
);
    logic [CW-1:0] pcnt_q;
    logic [CW-1:0] tcnt_q;

    assign tick = !hold && !raw_mode && (pcnt_q == div);
    assign last = raw_mode ? (!hold && (pcnt_q == lim)) : (tick && (tcnt_q == lim));
    assign tcnt = tcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            tcnt_q <= '0;
        end else if (restart) begin
            pcnt_q <= '0;
            tcnt_q <= '0;
        end else if (!hold) begin
            if (!raw_mode && (pcnt_q == div)) begin
                pcnt_q <= '0;
                tcnt_q <= tcnt_q + 1'b1;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // R8: a stretch hold freezes both counters
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !restart) |=> ($stable(pcnt_q) && $stable(tcnt_q)));

    // R1: between ticks the prescaler advances by exactly one per cycle
    p_prescale_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !hold && !raw_mode && (pcnt_q != div)) |=> (pcnt_q == $past(pcnt_q) + 1'b1));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_mode,
    input  logic [SET_W-1:0] fs_timing,
    input  logic [SET_W-1:0] hs_timing,
    input  logic [CNT_W-1:0] dat_hold,
    input  logic [FLT_W-1:0] flt_len,
    input  logic             cmd_go,
    input  logic [1:0]       cmd_op,
    input  logic             scl_in,
    output logic             scl_release,
    output logic             sda_own,
    output logic             sda_level,
    output logic             busy,
    output logic             drive_stb,
    output logic             sample_stb,
    output logic             done_stb
);
    tgen_state_e      state_q, state_d;
    tgen_timing_t     cfg;
    logic             idle_high_q, scl_q;
    logic             accept, phase_end, cnt_tick, cnt_last, cnt_hold, cnt_raw;
    logic [CNT_W-1:0] cnt_lim, tcnt, hold_pt, sync_lim;

    assign accept    = cmd_go && (state_q == ST_IDLE);
    assign phase_end = (state_q != ST_IDLE) && cnt_last;
    assign cnt_hold  = (state_q == ST_BIT_HI) && !scl_q;
    assign sync_lim  = CNT_W'(SYNC_BASE) + CNT_W'(cfg.flt);
    assign hold_pt   = (cfg.dat_hd > cfg.scl_lo) ? cfg.scl_lo : cfg.dat_hd;

    scl_tgen_select u_select (
        .clk(clk), .rst_n(rst_n), .load(accept), .hs_mode(hs_mode),
        .fs_set(fs_timing), .hs_set(hs_timing), .dat_hold(dat_hold),
        .flt_len(flt_len), .cfg(cfg)
    );

    scl_tgen_phase_cnt #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(accept || phase_end), .hold(cnt_hold),
        .raw_mode(cnt_raw), .div(cfg.div), .lim(cnt_lim),
        .tick(cnt_tick), .last(cnt_last), .tcnt(tcnt)
    );

    // Phase length for the current state
    always_comb begin
        cnt_lim = '0;
        cnt_raw = 1'b0;
        unique case (state_q)
            ST_IDLE:     cnt_lim = '0;
            ST_STA_SU:   cnt_lim = cfg.sta_su;
            ST_STA_HD:   cnt_lim = cfg.sta_hd;
            ST_STO_DAT:  cnt_lim = cfg.dat_su;
            ST_STO_SU:   cnt_lim = cfg.sto_su;
            ST_RS_REL:   cnt_lim = cfg.rs_rel;
            ST_BIT_LO:   cnt_lim = cfg.scl_lo;
            ST_BIT_HI:   cnt_lim = cfg.scl_hi;
            ST_BIT_RISE, ST_BIT_FALL: begin
                cnt_lim = sync_lim;
                cnt_raw = 1'b1;
            end
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_go) begin
                unique case (tgen_op_e'(cmd_op))
                    OP_BIT:     state_d = ST_BIT_LO;
                    OP_START:   state_d = ST_STA_SU;
                    OP_STOP:    state_d = ST_STO_DAT;
                    OP_RESTART: state_d = ST_RS_REL;
                endcase
            end
            ST_STA_SU:   if (phase_end) state_d = ST_STA_HD;
            ST_STA_HD:   if (phase_end) state_d = ST_IDLE;
            ST_STO_DAT:  if (phase_end) state_d = ST_STO_SU;
            ST_STO_SU:   if (phase_end) state_d = ST_IDLE;
            ST_RS_REL:   if (phase_end) state_d = ST_STA_SU;
            ST_BIT_LO:   if (phase_end) state_d = ST_BIT_RISE;
            ST_BIT_RISE: if (phase_end) state_d = ST_BIT_HI;
            ST_BIT_HI:   if (phase_end) state_d = ST_BIT_FALL;
            ST_BIT_FALL: if (phase_end) state_d = ST_IDLE;
        endcase
    end

    // State register, idle SCL level and registered SCL input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idle_high_q <= 1'b1;
            scl_q       <= 1'b1;
        end else begin
            state_q <= state_d;
            scl_q   <= scl_in;
            if (phase_end && (state_q == ST_STO_SU)) begin
                idle_high_q <= 1'b1;
            end else if (phase_end && ((state_q == ST_STA_HD) || (state_q == ST_BIT_FALL))) begin
                idle_high_q <= 1'b0;
            end
        end
    end

    // Output decode
    always_comb begin
        scl_release = 1'b1;
        sda_own     = 1'b0;
        sda_level   = 1'b1;
        unique case (state_q)
            ST_IDLE:    scl_release = idle_high_q;
            ST_STA_SU:  sda_own = 1'b1;
            ST_STA_HD:  begin sda_own = 1'b1; sda_level = 1'b0; end
            ST_STO_DAT: begin scl_release = 1'b0; sda_own = 1'b1; sda_level = 1'b0; end
            ST_STO_SU:  begin sda_own = 1'b1; sda_level = 1'b0; end
            ST_RS_REL:  begin scl_release = 1'b0; sda_own = 1'b1; end
            ST_BIT_LO:  scl_release = 1'b0;
            ST_BIT_RISE, ST_BIT_HI, ST_BIT_FALL: scl_release = 1'b1;
        endcase
    end

    assign busy       = (state_q != ST_IDLE);
    assign drive_stb  = (state_q == ST_BIT_LO) && cnt_tick && (tcnt == hold_pt);
    assign sample_stb = (state_q == ST_BIT_HI) && cnt_last;
    assign done_stb   = phase_end && ((state_q == ST_STA_HD) || (state_q == ST_STO_SU) ||
                                      (state_q == ST_BIT_FALL));

    // R7: the three strobes never coincide
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_stb, sample_stb, done_stb}));

    // R9: a finished sequence returns to idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> !busy);

    // R9: a command while busy does not move the state machine
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_go && !phase_end) |=> (state_q == $past(state_q)));

    // R10: the captured timing set is stable while busy
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));
endmodule

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
    import scl_tgen_pkg::*;

    typedef struct packed {
        logic scl, own, lvl, drv, smp, done, stretch, nidle;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_mode = 1'b0;
    logic [63:0] fs_timing = '0, hs_timing = '0;
    logic [7:0]  dat_hold = '0;
    logic [2:0]  flt_len = '0;
    logic        cmd_go = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        scl_in = 1'b1;
    logic        scl_release, sda_own, sda_level, busy, drive_stb, sample_stb, done_stb;

    always #10 clk = ~clk;   // 50 MHz

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .fs_timing(fs_timing),
        .hs_timing(hs_timing), .dat_hold(dat_hold), .flt_len(flt_len),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .scl_in(scl_in),
        .scl_release(scl_release), .sda_own(sda_own), .sda_level(sda_level),
        .busy(busy), .drive_stb(drive_stb), .sample_stb(sample_stb), .done_stb(done_stb)
    );

    int    checks = 0, errors = 0, cycles = 0, run_len = 0, last_len = 0;
    string cur_req = "R11";
    exp_t  q[$];
    exp_t  e_v;
    logic  idle_m = 1'b1, sclq_m = 1'b1, run = 1'b0, hold_v;
    logic [6:0] got_v, exp_v;

    function automatic logic [63:0] mkset(int d, int l, int h, int su, int hd, int so, int ds, int rr);
        return {d[7:0], l[7:0], h[7:0], su[7:0], hd[7:0], so[7:0], ds[7:0], rr[7:0]};
    endfunction

    task automatic check_vec(string req, logic [6:0] g, logic [6:0] e);
        checks++;
        if (g !== e) begin
            errors++;
            $display("FAIL %s: outputs got %b expected %b at cycle %0d", req, g, e, cycles);
        end
    endtask

    task automatic check_int(string req, int g, int e);
        checks++;
        if (g != e) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, g, e);
        end
    endtask

    always @(posedge clk) sclq_m <= scl_in;

    // Per-cycle comparison against the expected waveform
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (run) begin
            got_v = {scl_release, sda_own, sda_level, drive_stb, sample_stb, done_stb, busy};
            if (q.size() == 0) begin
                exp_v = {idle_m, 1'b0, 1'b1, 4'b0000};
            end else begin
                e_v    = q[0];
                hold_v = e_v.stretch && !sclq_m;
                if (hold_v) begin
                    exp_v = {e_v.scl, e_v.own, e_v.lvl, 3'b000, 1'b1};
                end else begin
                    exp_v = {e_v.scl, e_v.own, e_v.lvl, e_v.drv, e_v.smp, e_v.done, 1'b1};
                    void'(q.pop_front());
                    if (e_v.done) idle_m = e_v.nidle;
                end
            end
            check_vec(cur_req, got_v, exp_v);
            if (busy) run_len++;
            if (done_stb) begin
                last_len = run_len;
                run_len  = 0;
            end
        end
    end

    task automatic push_n(logic scl, logic own, logic lvl, int n, logic st,
                          int drv_at, logic smp_last, logic done_last, logic nid);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e       = '0;
            e.scl   = scl;
            e.own   = own;
            e.lvl   = lvl;
            e.stretch = st;
            e.drv   = (i == drv_at);
            e.smp   = smp_last && (i == n - 1);
            e.done  = done_last && (i == n - 1);
            e.nidle = nid;
            q.push_back(e);
        end
    endtask

    // Expected waveform from the requirements (R1..R7)
    task automatic plan(tgen_op_e op);
        logic [63:0] s;
        int d, l, h, su, hd, so, ds, rr, tk, k, f;
        s  = hs_mode ? hs_timing : fs_timing;   // R3
        d  = int'(s[63:56]); l  = int'(s[55:48]); h  = int'(s[47:40]);
        su = int'(s[39:32]); hd = int'(s[31:24]); so = int'(s[23:16]);
        ds = int'(s[15:8]);  rr = int'(s[7:0]);
        tk = d + 1;
        f  = int'(flt_len);
        k  = (int'(dat_hold) > l) ? l : int'(dat_hold);
        case (op)
            OP_BIT: begin
                push_n(1'b0, 1'b0, 1'b1, (l + 1) * tk, 1'b0, (k + 1) * tk - 1, 1'b0, 1'b0, 1'b0);
                push_n(1'b1, 1'b0, 1'b1, 4 + f, 1'b0, -1, 1'b0, 1'b0, 1'b0);
                push_n(1'b1, 1'b0, 1'b1, (h + 1) * tk, 1'b1, -1, 1'b1, 1'b0, 1'b0);
                push_n(1'b1, 1'b0, 1'b1, 4 + f, 1'b0, -1, 1'b0, 1'b1, 1'b0);
            end
            OP_START, OP_RESTART: begin
                if (op == OP_RESTART)
                    push_n(1'b0, 1'b1, 1'b1, (rr + 1) * tk, 1'b0, -1, 1'b0, 1'b0, 1'b0);
                push_n(1'b1, 1'b1, 1'b1, (su + 1) * tk, 1'b0, -1, 1'b0, 1'b0, 1'b0);
                push_n(1'b1, 1'b1, 1'b0, (hd + 1) * tk, 1'b0, -1, 1'b0, 1'b1, 1'b0);
            end
            OP_STOP: begin
                push_n(1'b0, 1'b1, 1'b0, (ds + 1) * tk, 1'b0, -1, 1'b0, 1'b0, 1'b1);
                push_n(1'b1, 1'b1, 1'b0, (so + 1) * tk, 1'b0, -1, 1'b0, 1'b1, 1'b1);
            end
            default: ;
        endcase
    endtask

    task automatic wait_idle();
        while (q.size() != 0) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
    endtask

    task automatic issue(tgen_op_e op);
        wait_idle();
        cmd_op = op;
        cmd_go = 1'b1;
        plan(op);
        @(negedge clk); #1;
        cmd_go = 1'b0;
    endtask

    initial begin
        logic [63:0] set_a, set_b, set_c, set_big;
        set_a   = mkset(1, 3, 2, 2, 3, 1, 0, 2);
        set_b   = mkset(0, 1, 1, 0, 0, 0, 1, 0);
        set_c   = mkset(2, 2, 4, 1, 1, 2, 1, 1);
        set_big = mkset(3, 200, 200, 0, 0, 0, 0, 0);

        // R11: reset state
        fs_timing = set_a; hs_timing = set_c; dat_hold = 8'd1; flt_len = 3'd2;
        repeat (3) @(negedge clk);
        check_vec("R11", {scl_release, sda_own, sda_level, drive_stb, sample_stb, done_stb, busy},
                  7'b1010000);
        #1 rst_n = 1'b1;
        run = 1'b1;
        repeat (2) @(negedge clk);
        #1;

        // Start, two bits, stop on the fast set
        cur_req = "R4"; issue(OP_START);
        cur_req = "R1"; issue(OP_BIT); wait_idle();
        check_int("R1", last_len, 26);
        cur_req = "R7"; issue(OP_BIT);
        cur_req = "R5"; issue(OP_STOP); wait_idle();

        // Minimum lengths, data hold beyond L (clamped), repeated start
        fs_timing = set_b; dat_hold = 8'd5; flt_len = 3'd0;
        cur_req = "R2"; issue(OP_START);
        cur_req = "R7"; issue(OP_BIT); wait_idle();
        check_int("R1", last_len, 12);
        cur_req = "R6"; issue(OP_RESTART);
        cur_req = "R2"; issue(OP_BIT);
        cur_req = "R5"; issue(OP_STOP); wait_idle();

        // High-speed set selection
        hs_mode = 1'b1; flt_len = 3'd1; dat_hold = 8'd1;
        cur_req = "R3"; issue(OP_START);
        issue(OP_BIT); wait_idle();
        check_int("R3", last_len, 34);
        issue(OP_STOP); wait_idle();
        hs_mode = 1'b0;

        // Clock stretching in the high phase
        fs_timing = set_a; flt_len = 3'd2;
        cur_req = "R8"; issue(OP_START);
        issue(OP_BIT);
        scl_in = 1'b0;
        repeat (25) begin @(negedge clk); #1; end
        scl_in = 1'b1;
        wait_idle();
        checks++;
        if (last_len <= 26) begin
            errors++;
            $display("FAIL R8: got %0d cycles expected more than 26", last_len);
        end

        // Command while busy is ignored
        cur_req = "R9"; issue(OP_BIT);
        repeat (4) begin @(negedge clk); #1; end
        cmd_op = 2'd1; cmd_go = 1'b1;
        repeat (3) begin @(negedge clk); #1; end
        cmd_go = 1'b0;
        wait_idle();
        check_int("R9", last_len, 26);

        // Timing change while busy has no effect
        cur_req = "R10"; issue(OP_BIT);
        fs_timing = set_b; hs_timing = set_b; dat_hold = 8'd0;
        wait_idle();
        check_int("R10", last_len, 26);
        fs_timing = set_a; dat_hold = 8'd1;

        // Long phases
        fs_timing = set_big;
        cur_req = "R1"; issue(OP_BIT); wait_idle();
        check_int("R1", last_len, 4 * 402 + 12);
        fs_timing = set_a;
        cur_req = "R5"; issue(OP_STOP); wait_idle();
        repeat (3) begin @(negedge clk); #1; end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule